// File: doc/BRIEF.md
# Link Integrity Pulse Monitor

This block decides whether a 10 Mb/s twisted-pair link may be used for transmission. It watches two one-cycle strobes from the receive side: one for each detected incoming link pulse, and one for receive activity. From these it keeps a transmit gate and a link status bit. The gate opens only after a link pulse has been seen. It stays open while pulses or receive data keep arriving. It closes with a one-cycle failure event once both have been silent for a programmable window.

When link testing is switched off, the gate is forced open and no failure is ever reported. When a failure happens while auto-negotiation is enabled, a one-cycle request to restart auto-negotiation goes out together with the failure event.

The block also times its own outgoing link pulses. It emits a strobe at a fixed period that never pauses, whatever the link state or the control bits. Both time intervals are given in clock cycles by parameters: a 16 ms pulse period and a 100 ms loss window at a 100 MHz clock by default.

Top module: `link_pulse_monitor`

## Requirements
- R1: `lp_out` is a one-cycle strobe that goes high after every PULSE_PERIOD clock edges. The first strobe follows the PULSE_PERIOD-th edge after reset is released. It keeps running whatever the link state, `test_off` and `an_on` are.
- R2: With `test_off`=0 and the link down, `tx_open` goes to 1 on the edge that samples `lp_seen`=1. A `rx_active` strobe alone leaves the gate closed.
- R3: While the gate is open, each `lp_seen` or `rx_active` strobe restarts the loss window, so regular strobes of either kind keep the gate open.
- R4: If LOSS_WINDOW edges pass after the last activity strobe with no further strobe, `tx_open` drops and `link_fail` is 1 for exactly that one cycle. A strobe sampled on the LOSS_WINDOW-th edge keeps the gate open.
- R5: While `test_off`=1, `tx_open` is 1 from the edge after it is set, and neither `link_fail` nor `an_restart` is raised.
- R6: `an_restart` is a one-cycle pulse in the same cycle as `link_fail`, and only if `an_on` was 1 on the edge that detected the failure.
- R7: `link_up` always equals `tx_open`. It therefore reads 1 while link testing is disabled.
- R8: A synchronous reset leaves `tx_open`, `link_up`, `link_fail`, `an_restart` and `lp_out` at 0 and restarts the pulse timer from zero.
- R9: Clearing `test_off` closes the gate on the next edge unless `lp_seen` is sampled on that edge. This raises no failure event, and the link must be found again by a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_seen | input | 1 | One-cycle strobe per detected incoming link pulse |
| rx_active | input | 1 | One-cycle strobe for receive data activity |
| test_off | input | 1 | 1 disables link testing and forces the gate open |
| an_on | input | 1 | 1 when auto-negotiation is enabled |
| tx_open | output | 1 | Transmit gate, 1 = transmission allowed |
| link_up | output | 1 | Link status bit |
| link_fail | output | 1 | One-cycle link failure event |
| an_restart | output | 1 | One-cycle request to restart auto-negotiation |
| lp_out | output | 1 | One-cycle outgoing link pulse strobe |

## Verification
Every output is a register. A strobe sampled on a clock edge therefore shows on `tx_open`, `link_up`, `link_fail` and `an_restart` right after that same edge, and a failure appears right after the LOSS_WINDOW-th quiet edge. The bench drives inputs on falling edges and samples one falling edge after each rising edge. Each table vector is held for a known number of edges, chosen so that a window ends exactly one edge before or exactly on a failure. The outgoing pulse spacing is measured in falling edges between strobes and must equal PULSE_PERIOD; the first strobe after reset must fall on the PULSE_PERIOD-th edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic {
    LNK_DOWN = 1'b0,
    LNK_UP   = 1'b1
  } link_st_e;
endpackage

// File: rtl/lpm_tx_pulse_gen.sv
module lpm_tx_pulse_gen #(
  parameter int PULSE_PERIOD = 1_600_000
) (
  input  logic clk,
  input  logic rst,
  output logic lp_out
);
  localparam int CW = (PULSE_PERIOD > 2) ? $clog2(PULSE_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSE_PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      lp_out <= 1'b0;
    end else begin
      lp_out <= (cnt == LAST);
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/lpm_idle_timer.sv
module lpm_idle_timer #(
  parameter int LOSS_WINDOW = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic expire
);
  localparam int WW = (LOSS_WINDOW > 2) ? $clog2(LOSS_WINDOW) : 1;
  localparam logic [WW-1:0] LAST = WW'(LOSS_WINDOW - 1);

  logic [WW-1:0] cnt;

  // Quiet-cycle count; expiry is flagged on the edge that would pass the window.
  assign expire = !clear && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + WW'(1);
  end
endmodule

// File: rtl/lpm_link_fsm.sv
module lpm_link_fsm
  import lpm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lp_seen,
  input  logic test_off,
  input  logic an_on,
  input  logic expire,
  output logic is_up,
  output logic tx_open,
  output logic link_fail,
  output logic an_restart
);
  link_st_e st, st_n;
  logic     fail_n;

  always_comb begin
    st_n   = st;
    fail_n = 1'b0;
    if (test_off) begin
      st_n = LNK_DOWN;
    end else begin
      case (st)
        LNK_DOWN: if (lp_seen) st_n = LNK_UP;
        LNK_UP: if (expire) begin
          st_n   = LNK_DOWN;
          fail_n = 1'b1;
        end
        default: st_n = LNK_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= LNK_DOWN;
      tx_open    <= 1'b0;
      link_fail  <= 1'b0;
      an_restart <= 1'b0;
    end else begin
      st         <= st_n;
      tx_open    <= test_off || (st_n == LNK_UP);
      link_fail  <= fail_n;
      an_restart <= fail_n && an_on;
    end
  end

  assign is_up = (st == LNK_UP);
endmodule

// File: rtl/link_pulse_monitor.sv
module link_pulse_monitor #(
  parameter int PULSE_PERIOD = 1_600_000,
  parameter int LOSS_WINDOW  = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic lp_seen,
  input  logic rx_active,
  input  logic test_off,
  input  logic an_on,
  output logic tx_open,
  output logic link_up,
  output logic link_fail,
  output logic an_restart,
  output logic lp_out
);
  logic is_up;
  logic expire;
  logic timer_clear;
  logic gate_q;

  assign timer_clear = lp_seen || rx_active || !is_up || test_off;

  lpm_tx_pulse_gen #(.PULSE_PERIOD(PULSE_PERIOD)) u_pgen (
    .clk    (clk),
    .rst    (rst),
    .lp_out (lp_out)
  );

  lpm_idle_timer #(.LOSS_WINDOW(LOSS_WINDOW)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .clear  (timer_clear),
    .expire (expire)
  );

  lpm_link_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .lp_seen    (lp_seen),
    .test_off   (test_off),
    .an_on      (an_on),
    .expire     (expire),
    .is_up      (is_up),
    .tx_open    (gate_q),
    .link_fail  (link_fail),
    .an_restart (an_restart)
  );

  assign tx_open = gate_q;
  assign link_up = gate_q;
endmodule

// File: rtl/lpm_chk.sv
module lpm_chk #(
  parameter int PULSE_PERIOD = 1_600_000,
  parameter int LOSS_WINDOW  = 10_000_000
) (
  input logic clk,
  input logic rst,
  input logic lp_seen,
  input logic rx_active,
  input logic test_off,
  input logic an_on,
  input logic tx_open,
  input logic link_up,
  input logic link_fail,
  input logic an_restart,
  input logic lp_out
);
  localparam int SW = $clog2(PULSE_PERIOD + 1);
  localparam int QW = $clog2(LOSS_WINDOW + 2);

  logic [SW-1:0] since_lp;
  logic          seen_lp;
  logic [QW-1:0] quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_lp <= '0;
      seen_lp  <= 1'b0;
      quiet    <= QW'(LOSS_WINDOW + 1);
    end else begin
      if (lp_out) begin
        since_lp <= '0;
        seen_lp  <= 1'b1;
      end else if (since_lp != SW'(PULSE_PERIOD)) begin
        since_lp <= since_lp + SW'(1);
      end
      if (lp_seen || rx_active) quiet <= '0;
      else if (quiet != QW'(LOSS_WINDOW + 1)) quiet <= quiet + QW'(1);
    end
  end

  // R1
  lp_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (lp_out && seen_lp) |-> (since_lp == SW'(PULSE_PERIOD - 1)));
  // R1
  lp_single_chk: assert property (@(posedge clk) disable iff (rst)
    lp_out |=> !lp_out);
  // R2
  gate_open_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_open) |-> ($past(lp_seen) || $past(test_off)));
  // R4
  fail_window_chk: assert property (@(posedge clk) disable iff (rst)
    link_fail |-> (quiet == QW'(LOSS_WINDOW)));
  // R4
  fail_closes_chk: assert property (@(posedge clk) disable iff (rst)
    link_fail |-> $fell(tx_open));
  // R4
  fail_single_chk: assert property (@(posedge clk) disable iff (rst)
    link_fail |=> !link_fail);
  // R5
  bypass_open_chk: assert property (@(posedge clk) disable iff (rst)
    $past(test_off) |-> (tx_open && !link_fail && !an_restart));
  // R6
  restart_follows_an_chk: assert property (@(posedge clk) disable iff (rst)
    link_fail |-> (an_restart == $past(an_on)));
  // R6
  restart_needs_fail_chk: assert property (@(posedge clk) disable iff (rst)
    an_restart |-> link_fail);
  // R7
  status_match_chk: assert property (@(posedge clk) disable iff (rst)
    link_up == tx_open);
endmodule

bind link_pulse_monitor lpm_chk #(
  .PULSE_PERIOD(PULSE_PERIOD),
  .LOSS_WINDOW (LOSS_WINDOW)
) u_lpm_chk (
  .clk        (clk),
  .rst        (rst),
  .lp_seen    (lp_seen),
  .rx_active  (rx_active),
  .test_off   (test_off),
  .an_on      (an_on),
  .tx_open    (tx_open),
  .link_up    (link_up),
  .link_fail  (link_fail),
  .an_restart (an_restart),
  .lp_out     (lp_out)
);

// File: tb/tb_link_pulse_monitor.sv
module tb_link_pulse_monitor;
  localparam int P = 20;
  localparam int W = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lp_seen = 1'b0, rx_active = 1'b0, test_off = 1'b0, an_on = 1'b0;
  logic tx_open, link_up, link_fail, an_restart, lp_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  link_pulse_monitor #(.PULSE_PERIOD(P), .LOSS_WINDOW(W)) dut (
    .clk(clk), .rst(rst), .lp_seen(lp_seen), .rx_active(rx_active),
    .test_off(test_off), .an_on(an_on), .tx_open(tx_open), .link_up(link_up),
    .link_fail(link_fail), .an_restart(an_restart), .lp_out(lp_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic       lp;
    logic       rx;
    logic       toff;
    logic       an;
    logic [7:0] len;
    logic       e_open;
    logic       e_fail;
    logic       e_rst;
  } vec_t;

  // One strobe, then the vector is held for len edges in total.
  localparam vec_t VECS [0:11] = '{
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd5,  1'b0, 1'b0, 1'b0}, // R2 idle, closed
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd5,  1'b0, 1'b0, 1'b0}, // R2 rx alone stays closed
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'd50, 1'b1, 1'b0, 1'b0}, // R2 R4 open, one edge short of loss
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd50, 1'b1, 1'b0, 1'b0}, // R3 R4 rx on the last edge keeps it
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 1'b1, 1'b1}, // R4 R6 fail with restart
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'd60, 1'b0, 1'b1, 1'b0}, // R4 R6 fail, no restart
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd5,  1'b1, 1'b0, 1'b0}, // R5 bypass opens gate
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd80, 1'b1, 1'b0, 1'b0}, // R5 no fail while bypassed
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 1'b0, 1'b0}, // R9 bypass cleared, closed
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'd3,  1'b1, 1'b0, 1'b0}, // R2 reopened by pulse
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd2,  1'b1, 1'b0, 1'b0}, // R5 bypass while up
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd2,  1'b0, 1'b0, 1'b0}  // R9 no event on clearing
  };

  // R1: spacing of outgoing pulses, measured at every falling edge
  int  gap = 0;
  bit  seen = 1'b0;
  always @(negedge clk) begin
    #1;
    if (rst) begin
      gap  = 0;
      seen = 1'b0;
    end else begin
      gap++;
      if (lp_out) begin
        if (seen) check("R1 pulse spacing", gap, P);
        seen = 1'b1;
        gap  = 0;
      end
    end
  end

  initial begin
    bit fail_seen, rst_seen;
    int first_at, second_at;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 tx_open in reset", int'(tx_open), 0);
    check("R8 link_up in reset", int'(link_up), 0);
    check("R8 lp_out in reset", int'(lp_out), 0);
    rst = 1'b0;

    for (int i = 0; i < 12; i++) begin
      lp_seen   = VECS[i].lp;
      rx_active = VECS[i].rx;
      test_off  = VECS[i].toff;
      an_on     = VECS[i].an;
      fail_seen = 1'b0;
      rst_seen  = 1'b0;
      for (int k = 1; k <= int'(VECS[i].len); k++) begin
        @(negedge clk);
        lp_seen   = 1'b0;
        rx_active = 1'b0;
        if (link_fail)  fail_seen = 1'b1;
        if (an_restart) rst_seen  = 1'b1;
        // R7 status tracks gate
        if (link_up != tx_open) check("R7 link_up vs tx_open", int'(link_up), int'(tx_open));
      end
      check($sformatf("vec%0d R2/R4/R5/R9 tx_open", i), int'(tx_open), int'(VECS[i].e_open));
      check($sformatf("vec%0d R4 link_fail", i), int'(fail_seen), int'(VECS[i].e_fail));
      check($sformatf("vec%0d R6 an_restart", i), int'(rst_seen), int'(VECS[i].e_rst));
      check($sformatf("vec%0d R7 link_up", i), int'(link_up), int'(VECS[i].e_open));
    end

    // R8: reset while the link is up
    lp_seen = 1'b1;
    @(negedge clk);
    lp_seen = 1'b0;
    check("R2 open before reset", int'(tx_open), 1);
    rst = 1'b1;
    @(negedge clk);
    check("R8 tx_open after reset", int'(tx_open), 0);
    check("R8 link_up after reset", int'(link_up), 0);
    check("R8 link_fail after reset", int'(link_fail), 0);
    check("R8 an_restart after reset", int'(an_restart), 0);

    // R1: first pulses from reset, with bypass set and link down
    test_off  = 1'b1;
    rst       = 1'b0;
    first_at  = -1;
    second_at = -1;
    for (int n = 1; n <= 3 * P; n++) begin
      @(negedge clk);
      if (lp_out) begin
        if (first_at < 0) first_at = n;
        else if (second_at < 0) second_at = n;
      end
    end
    check("R1 first pulse edge", first_at, P);
    check("R1 second pulse edge", second_at, 2 * P);
    check("R5 gate open during bypass", int'(tx_open), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule